// File: doc/BRIEF.md
# In-Stream Tagged Interrupt Generator

This block sits at the consuming end of a command queue and watches each word that reaches the head. An ordinary command is handed straight to the executor. A word whose top byte carries the interrupt-request marker is not a command. It is an interrupt request placed in the stream by the host, and it carries a tag of `TAG_W` bits (16 or 24). Because the request is taken only when it reaches the head, every command queued before it has already been consumed. No later command can reach the executor before the interrupt line is up.

Captured tags wait in a small in-order pending buffer, so execution continues while the host services an interrupt. A set of hardware event inputs is also gathered into the same identification word, under a nonzero source code in its top byte. The host reads the identification word and learns which software request fired, or which hardware source did. It then writes the acknowledge bit to retire that entry. A global enable bit masks the interrupt line but keeps all captured state.

Top module: `tagirq_gen`

## Requirements
- R1: After reset `irq`, `ovf` and `id_rdata` are 0, the global enable is off, and `head_pop` is 0 while `head_valid` is 0.
- R2: A head word whose bits [31:24] differ from the marker 0xC9 is presented on `exec_valid`/`exec_word` in the same cycle, and `head_pop` equals `exec_ready`. A marker word never appears on `exec_valid`.
- R3: A marker word at the head is popped in the same cycle. From the next cycle `id_rdata` holds its low `TAG_W` bits (default 24) with 0x00 in bits [31:24], and `irq` is 1 when enabled.
- R4: The command that follows a request can reach the executor no earlier than the cycle after the request is popped, and `irq` is already 1 in that cycle.
- R5: A pulse on `hw_evt[i]` makes that source pending from the next cycle. When no software tag is pending, `id_rdata` shows code i+1 in bits [31:24] and zeros below, and the lowest pending index is shown first.
- R6: While any software tag is pending, `id_rdata` shows the oldest one ahead of any hardware source.
- R7: A write with `ctl_wr`=1 and `ctl_wdata[0]`=1 retires the entry shown in `id_rdata` from the next cycle. `irq` falls when nothing else is pending.
- R8: Up to `PEND_DEPTH` (default 2) requests are held and shown in arrival order. Each acknowledge advances to the next one.
- R9: A request that meets a full buffer is popped and dropped, and it sets `ovf` from the next cycle. `ovf` stays set until the next acknowledge.
- R10: `ctl_wdata[1]` written with `ctl_wr` sets the global enable from the next cycle. With the enable off, `irq` is 0 while the pending tags and `id_rdata` are kept. Turning the enable back on raises `irq` with the same ID.
- R11: With the default `CLEAR_ON_READ`=0, a pulse on `id_rd` changes neither `id_rdata` nor `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_valid | input | 1 | A word is present at the queue head |
| head_word | input | WORD_W | Word at the queue head |
| head_pop | output | 1 | Head word consumed this cycle |
| exec_valid | output | 1 | Ordinary command offered to the executor |
| exec_word | output | WORD_W | Command offered to the executor |
| exec_ready | input | 1 | Executor takes the command this cycle |
| hw_evt | input | HW_SRC | Hardware event pulses, source i reports code i+1 |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 2 | Bit 0 acknowledge, bit 1 global enable |
| id_rd | input | 1 | Identification read strobe |
| id_rdata | output | WORD_W | Identification word: source code on top, tag below |
| irq | output | 1 | Interrupt line |
| ovf | output | 1 | A request was dropped on a full buffer |

## Verification
The head-side results (`head_pop`, `exec_valid`, `exec_word`) are combinational and due in the same cycle the word is driven. The bench checks them a moment after driving, before the next edge. Captured IDs, hardware codes, the effect of an acknowledge or an enable write, and `ovf` each pass through one register and are due one cycle after the stimulus. Inputs change on the falling edge, and these results are sampled at the next falling edge, after exactly one rising edge. The ordering check presents the following command in the cycle right after the request, where `irq` must already be high.

// File: rtl/tagirq_pkg.sv
package tagirq_pkg;
   localparam int MARK_W = 8;
   localparam int CODE_W = 8;
   localparam int CTL_ACK = 0;
   localparam int CTL_EN  = 1;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_SW   = 2'd1,
      SRC_HW   = 2'd2
   } src_e;

   function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned depth);
      return (v + 1 == depth) ? 0 : v + 1;
   endfunction
endpackage

// File: rtl/tagirq_decode.sv
module tagirq_decode #(
   parameter int WORD_W = 32,
   parameter int TAG_W = 24,
   parameter logic [7:0] REQ_MARK = 8'hC9
) (
   input  logic [WORD_W-1:0] word,
   output logic              is_req,
   output logic [TAG_W-1:0]  tag
);
   import tagirq_pkg::*;
   logic [MARK_W-1:0] mark;

   always_comb begin
      mark   = word[WORD_W-1 -: MARK_W];
      is_req = (mark == REQ_MARK);
      tag    = word[TAG_W-1:0];
   end
endmodule

// File: rtl/tagirq_pendq.sv
module tagirq_pendq #(
   parameter int W = 24,
   parameter int DEPTH = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [W-1:0]               wdata,
   input  logic                       pop,
   output logic [W-1:0]               rdata,
   output logic                       empty,
   output logic                       full,
   output logic [$clog2(DEPTH+1)-1:0] count
);
   import tagirq_pkg::*;
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);
   localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rd_ptr, wr_ptr;
   logic          do_push, do_pop;

   always_comb begin
      empty   = (count == '0);
      full    = (count == CNT_MAX);
      do_pop  = pop && !empty;
      do_push = push && (!full || do_pop);
      rdata   = mem[rd_ptr];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= AW'(wrap_inc(int'(wr_ptr), DEPTH));
         if (do_pop)  rd_ptr <= AW'(wrap_inc(int'(rd_ptr), DEPTH));
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n) mem[i] <= '0;
            else if (do_push && wr_ptr == AW'(i)) mem[i] <= wdata;
         end
      end
   endgenerate
endmodule

// File: rtl/tagirq_hwsrc.sv
module tagirq_hwsrc #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic         clr,
   output logic         any,
   output logic [7:0]   code
);
   logic [N-1:0] pend;
   logic [N-1:0] sel;

   always_comb begin
      sel  = '0;
      code = 8'h00;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend[i]) begin
            sel  = '0;
            sel[i] = 1'b1;
            code = 8'(i + 1);
         end
      end
      any = |pend;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend & ~(clr ? sel : '0)) | evt;
   end
endmodule

// File: rtl/tagirq_gen.sv
module tagirq_gen #(
   parameter int WORD_W = 32,
   parameter int TAG_W = 24,
   parameter int PEND_DEPTH = 2,
   parameter int HW_SRC = 2,
   parameter logic [7:0] REQ_MARK = 8'hC9,
   parameter bit STALL_ON_FULL = 1'b0,
   parameter bit CLEAR_ON_READ = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              head_valid,
   input  logic [WORD_W-1:0] head_word,
   output logic              head_pop,
   output logic              exec_valid,
   output logic [WORD_W-1:0] exec_word,
   input  logic              exec_ready,
   input  logic [HW_SRC-1:0] hw_evt,
   input  logic              ctl_wr,
   input  logic [1:0]        ctl_wdata,
   input  logic              id_rd,
   output logic [WORD_W-1:0] id_rdata,
   output logic              irq,
   output logic              ovf
);
   import tagirq_pkg::*;
   localparam int CW = $clog2(PEND_DEPTH+1);

   initial begin
      assert (TAG_W == 16 || TAG_W == 24) else $error("TAG_W must be 16 or 24");
      assert (WORD_W >= TAG_W + MARK_W) else $error("WORD_W too narrow");
      assert (PEND_DEPTH >= 2) else $error("PEND_DEPTH must be at least 2");
      assert (HW_SRC >= 1 && HW_SRC <= 255) else $error("HW_SRC out of range");
   end

   logic              is_req;
   logic [TAG_W-1:0]  tag;
   logic              req_at_head;
   logic              q_push, q_pop, q_empty, q_full, q_space;
   logic [TAG_W-1:0]  q_rdata;
   logic [CW-1:0]     q_count;
   logic              hw_any, hw_clr;
   logic [7:0]        hw_code;
   logic              accept_req, drop;
   logic              clr_req, ack_wr;
   logic              en_q, ovf_q;
   src_e              shown;

   tagirq_decode #(.WORD_W(WORD_W), .TAG_W(TAG_W), .REQ_MARK(REQ_MARK)) u_dec (
      .word(head_word), .is_req(is_req), .tag(tag)
   );

   tagirq_pendq #(.W(TAG_W), .DEPTH(PEND_DEPTH)) u_q (
      .clk(clk), .rst_n(rst_n), .push(q_push), .wdata(tag), .pop(q_pop),
      .rdata(q_rdata), .empty(q_empty), .full(q_full), .count(q_count)
   );

   tagirq_hwsrc #(.N(HW_SRC)) u_hw (
      .clk(clk), .rst_n(rst_n), .evt(hw_evt), .clr(hw_clr),
      .any(hw_any), .code(hw_code)
   );

   assign ack_wr = ctl_wr && ctl_wdata[CTL_ACK];

   generate
      if (CLEAR_ON_READ) begin : g_rdclr
         assign clr_req = ack_wr || id_rd;
      end else begin : g_wrclr
         assign clr_req = ack_wr;
      end
   endgenerate

   always_comb begin
      q_pop   = clr_req && !q_empty;
      hw_clr  = clr_req && q_empty && hw_any;
      q_space = !q_full || q_pop;
      req_at_head = head_valid && is_req;
   end

   generate
      if (STALL_ON_FULL) begin : g_stall
         assign accept_req = q_space;
      end else begin : g_drop
         assign accept_req = 1'b1;
      end
   endgenerate

   always_comb begin
      q_push     = req_at_head && q_space;
      drop       = req_at_head && accept_req && !q_space;
      exec_valid = head_valid && !is_req;
      exec_word  = head_word;
      head_pop   = head_valid && (is_req ? accept_req : exec_ready);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         ovf_q <= 1'b0;
      end else begin
         if (ctl_wr) en_q <= ctl_wdata[CTL_EN];
         if (drop)         ovf_q <= 1'b1;
         else if (clr_req) ovf_q <= 1'b0;
      end
   end

   always_comb begin
      if (!q_empty)   shown = SRC_SW;
      else if (hw_any) shown = SRC_HW;
      else            shown = SRC_NONE;
      id_rdata = '0;
      case (shown)
         SRC_SW:  id_rdata[TAG_W-1:0] = q_rdata;
         SRC_HW:  id_rdata[WORD_W-1 -: CODE_W] = hw_code;
         default: id_rdata = '0;
      endcase
      irq = en_q && (shown != SRC_NONE);
      ovf = ovf_q;
   end
endmodule

// File: rtl/tagirq_gen_chk.sv
module tagirq_gen_chk #(
   parameter int WORD_W = 32,
   parameter logic [7:0] REQ_MARK = 8'hC9,
   parameter int HW_SRC = 2,
   parameter bit CLEAR_ON_READ = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              head_valid,
   input logic [WORD_W-1:0] head_word,
   input logic              head_pop,
   input logic              exec_valid,
   input logic [WORD_W-1:0] exec_word,
   input logic [HW_SRC-1:0] hw_evt,
   input logic              ctl_wr,
   input logic [1:0]        ctl_wdata,
   input logic              id_rd,
   input logic [WORD_W-1:0] id_rdata,
   input logic              irq,
   input logic              ovf,
   input logic              en_q,
   input logic              q_empty
);
   logic clr_seen;
   assign clr_seen = (ctl_wr && ctl_wdata[0]) || (CLEAR_ON_READ && id_rd);

   a_r2_marker_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
      exec_valid |-> exec_word[WORD_W-1 -: 8] != REQ_MARK);

   a_r3_request_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (head_valid && head_pop && head_word[WORD_W-1 -: 8] == REQ_MARK) |=> (irq || !en_q));

   a_r5_hw_event_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_evt != '0) |=> (irq || !en_q));

   a_r6_software_shown_first: assert property (@(posedge clk) disable iff (!rst_n)
      !q_empty |-> id_rdata[WORD_W-1 -: 8] == 8'h00);

   a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr_seen) |=> ovf);

   a_r10_disable_masks: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !ctl_wdata[1]) |=> !irq);
endmodule

bind tagirq_gen tagirq_gen_chk #(
   .WORD_W(WORD_W), .REQ_MARK(REQ_MARK), .HW_SRC(HW_SRC), .CLEAR_ON_READ(CLEAR_ON_READ)
) u_chk (
   .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .head_word(head_word),
   .head_pop(head_pop), .exec_valid(exec_valid), .exec_word(exec_word),
   .hw_evt(hw_evt), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .id_rd(id_rd),
   .id_rdata(id_rdata), .irq(irq), .ovf(ovf), .en_q(en_q), .q_empty(q_empty)
);

// File: tb/tagirq_gen_test.sv
module tagirq_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        head_valid = 1'b0;
   logic [31:0] head_word = '0;
   logic        head_pop;
   logic        exec_valid;
   logic [31:0] exec_word;
   logic        exec_ready = 1'b0;
   logic [1:0]  hw_evt = '0;
   logic        ctl_wr = 1'b0;
   logic [1:0]  ctl_wdata = '0;
   logic        id_rd = 1'b0;
   logic [31:0] id_rdata;
   logic        irq;
   logic        ovf;

   int n_chk = 0;
   int n_err = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tagirq_gen uut (
      .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .head_word(head_word),
      .head_pop(head_pop), .exec_valid(exec_valid), .exec_word(exec_word),
      .exec_ready(exec_ready), .hw_evt(hw_evt), .ctl_wr(ctl_wr),
      .ctl_wdata(ctl_wdata), .id_rd(id_rd), .id_rdata(id_rdata),
      .irq(irq), .ovf(ovf)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic req_word(input logic [23:0] t);
      @(negedge clk);
      head_valid = 1'b1;
      head_word  = {8'hC9, t};
   endtask

   task automatic idle_head();
      @(negedge clk);
      head_valid = 1'b0;
      head_word  = '0;
   endtask

   task automatic ctl(input logic [1:0] v);
      @(negedge clk);
      ctl_wr = 1'b1;
      ctl_wdata = v;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 irq", 32'(irq), 0);
      chk("R1 ovf", 32'(ovf), 0);
      chk("R1 id", id_rdata, 0);
      chk("R1 pop", 32'(head_pop), 0);
   endtask

   task automatic t_passthru();
      @(negedge clk);
      head_valid = 1'b1; head_word = 32'h1234_5678; exec_ready = 1'b1;
      #1;
      chk("R2 exec_valid", 32'(exec_valid), 1);
      chk("R2 exec_word", exec_word, 32'h1234_5678);
      chk("R2 pop ready", 32'(head_pop), 1);
      exec_ready = 1'b0;
      #1;
      chk("R2 pop stall", 32'(head_pop), 0);
      idle_head();
      chk("R2 no irq", 32'(irq), 0);
   endtask

   task automatic t_single();
      req_word(24'hABCDEF);
      #1;
      chk("R3 pop request", 32'(head_pop), 1);
      chk("R2 request hidden", 32'(exec_valid), 0);
      @(negedge clk);
      head_word = 32'h1111_2222; exec_ready = 1'b1;
      #1;
      chk("R4 next cmd offered", 32'(exec_valid), 1);
      chk("R4 irq already up", 32'(irq), 1);
      chk("R3 id tag", id_rdata, 32'h00AB_CDEF);
      idle_head();
      exec_ready = 1'b0;
      ctl(2'b11);
      chk("R7 irq cleared", 32'(irq), 0);
      chk("R7 id cleared", id_rdata, 0);
   endtask

   task automatic t_queue();
      req_word(24'h000011);
      req_word(24'h000022);
      idle_head();
      chk("R8 first", id_rdata, 32'h0000_0011);
      ctl(2'b11);
      chk("R8 second", id_rdata, 32'h0000_0022);
      chk("R8 irq held", 32'(irq), 1);
      ctl(2'b11);
      chk("R8 drained", 32'(irq), 0);
   endtask

   task automatic t_overflow();
      req_word(24'h000031);
      req_word(24'h000032);
      req_word(24'h000033);
      #1;
      chk("R9 dropped word popped", 32'(head_pop), 1);
      idle_head();
      chk("R9 ovf set", 32'(ovf), 1);
      chk("R9 oldest kept", id_rdata, 32'h0000_0031);
      ctl(2'b11);
      chk("R9 ovf cleared", 32'(ovf), 0);
      chk("R9 second kept", id_rdata, 32'h0000_0032);
      ctl(2'b11);
      chk("R9 third dropped", 32'(irq), 0);
   endtask

   task automatic t_hw();
      @(negedge clk); hw_evt = 2'b10;
      @(negedge clk); hw_evt = 2'b00;
      chk("R5 code 2", id_rdata, 32'h0200_0000);
      chk("R5 irq", 32'(irq), 1);
      @(negedge clk); hw_evt = 2'b01;
      @(negedge clk); hw_evt = 2'b00;
      chk("R5 lowest first", id_rdata, 32'h0100_0000);
      ctl(2'b11);
      chk("R5 next source", id_rdata, 32'h0200_0000);
      ctl(2'b11);
      chk("R5 drained", 32'(irq), 0);
   endtask

   task automatic t_prio();
      @(negedge clk); hw_evt = 2'b01;
      @(negedge clk); hw_evt = 2'b00;
      req_word(24'h000055);
      idle_head();
      chk("R6 software first", id_rdata, 32'h0000_0055);
      ctl(2'b11);
      chk("R6 hardware after", id_rdata, 32'h0100_0000);
      ctl(2'b11);
      chk("R6 drained", 32'(irq), 0);
   endtask

   task automatic t_mask();
      ctl(2'b00);
      req_word(24'h000077);
      idle_head();
      chk("R10 masked irq", 32'(irq), 0);
      chk("R10 tag kept", id_rdata, 32'h0000_0077);
      ctl(2'b10);
      chk("R10 unmasked irq", 32'(irq), 1);
      chk("R10 same id", id_rdata, 32'h0000_0077);
      ctl(2'b11);
   endtask

   task automatic t_read();
      req_word(24'h000088);
      idle_head();
      @(negedge clk); id_rd = 1'b1;
      @(negedge clk); id_rd = 1'b0;
      chk("R11 id unchanged", id_rdata, 32'h0000_0088);
      chk("R11 irq unchanged", 32'(irq), 1);
      ctl(2'b11);
      chk("R7 final clear", 32'(irq), 0);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_passthru();
      ctl(2'b10);
      t_single();
      t_queue();
      t_overflow();
      t_hw();
      t_prio();
      t_mask();
      t_read();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule